// File: doc/BRIEF.md
# Multi-Hit Channel Acquisition Sequencer

This block runs the acquisition cycle of a multi-channel front-end readout chip. A start request opens an acquire window of fixed length. During that window each enabled channel may capture up to four hit records. A record holds the value of a free-running time counter at the moment of the trigger, together with a gain-range flag. A trigger comes from the channel's own discriminator, or from a shared external strobe, and a calibration strobe can inject a hit at any time.

When the window closes, a digitize phase sweeps a ramp counter once over its full range. Each stored record latches the count at which its comparator first fires. If the comparator never fires, the record saturates at full scale and sets an overflow bit. A readout phase then shifts nine words per channel out on one serial line while a frame-valid signal is held high, and a one-cycle done pulse closes the frame. No new cycle can start until the frame has been shifted out.

The analog front-end is outside the block. Its discriminators and ramp comparators appear as plain inputs.

Top module: `hit_acq_seq`

## Requirements
- R1: A start request in the idle phase (phase code 0) moves the block to acquire (code 1) for ACQ_LEN cycles, then to digitize (code 2) for 2^ADC_W cycles, then to readout (code 3) for NCH*9*WORD_W cycles, and then back to idle.
- R2: A channel keeps at most four records per cycle. A trigger on a channel that already holds four records is ignored. The record count of a channel appears in bits [2:0] of its first readout word.
- R3: A record's timestamp equals the number of acquire cycles that passed before the cycle in which the trigger was sampled. The first acquire cycle gives 0.
- R4: A record's range flag equals the range discriminator input of that channel in the cycle the hit was taken.
- R5: With trigSel=0, a channel triggers on its own discHit bit. With trigSel=1, extTrig triggers every channel. A channel whose chanEn bit is 0 records nothing.
- R6: calStrobe triggers every enabled channel in either trigger mode.
- R7: In digitize, a valid record stores the ramp count (0 in the first digitize cycle, then counting up) of the first cycle in which its rampCmp bit (index channel*4+record) is high.
- R8: If the comparator of a valid record never fires, the record stores 2^ADC_W-1 and its overflow bit is set.
- R9: Readout sends channels in ascending order. Each channel sends 9 words of WORD_W bits, MSB first.
  - Word 0 holds the count in [2:0] and the channel index from bit 3.
  - Words 1-4 give record k=word-1 as {valid, range, timestamp}, with the timestamp in the low TS_W bits.
  - Words 5-8 give record k=word-5 as {overflow, amplitude}, with the amplitude in the low ADC_W bits.
  - Unused records read as zero.
  - frameValid is high exactly during readout, and serOut is 0 outside readout.
- R10: doneP is high for one cycle, the cycle right after the last readout bit.
- R11: A start request outside the idle phase, including one made during readout, is ignored.
- R12: After reset the phase is idle, and frameValid, serOut and doneP are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin an acquisition cycle |
| trigSel | input | 1 | 0: per-channel self trigger, 1: external trigger |
| extTrig | input | 1 | Shared external trigger |
| calStrobe | input | 1 | Calibration injection on all enabled channels |
| chanEn | input | NCH | Per-channel enable |
| discHit | input | NCH | Per-channel hit discriminator |
| rangeDisc | input | NCH | Per-channel range-threshold discriminator |
| rampCmp | input | NCH*4 | Ramp comparator per stored record |
| phase | output | 2 | Current phase code |
| serOut | output | 1 | Serial readout data |
| frameValid | output | 1 | High during readout |
| doneP | output | 1 | End-of-frame pulse |

## Verification
The bench runs four full cycles that cover both trigger modes, calibration injection and partial channel enables. Hit densities are high enough that channels overflow their four slots: a design that overwrote or kept counting would show a wrong count or wrong timestamps in words 0 to 4. The comparator targets include values beyond full scale, so a converter that wrapped instead of saturating, or left the overflow bit clear, would show up in words 5 to 8. A start pulse in the middle of readout checks that the frame is not cut short. The phase lengths are checked at each boundary, which catches off-by-one timing.

// File: rtl/hit_acq_pkg.sv
package hit_acq_pkg;
  localparam int NREC = 4;
  localparam int WORDS = 1 + 2 * NREC;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_DIG  = 2'd2,
    PH_READ = 2'd3
  } phase_e;

  typedef struct packed {
    logic clr;
    logic acq;
    logic dig;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/hit_acq_ctrl.sv
module hit_acq_ctrl
  import hit_acq_pkg::*;
#(
  parameter int ACQ_LEN = 40,
  parameter int DIG_LEN = 64,
  parameter int READ_LEN = 360
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output phase_e  state,
  output strobe_t st,
  output logic    doneP
);
  localparam int CNT_W = $clog2(ACQ_LEN + DIG_LEN + READ_LEN) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseLen;
  logic lastCnt;

  always_comb begin
    case (state)
      PH_ACQ:  phaseLen = CNT_W'(ACQ_LEN);
      PH_DIG:  phaseLen = CNT_W'(DIG_LEN);
      PH_READ: phaseLen = CNT_W'(READ_LEN);
      default: phaseLen = CNT_W'(1);
    endcase
    lastCnt = (cnt == phaseLen - CNT_W'(1));
    st = '0;
    st.clr = (state == PH_IDLE) && startReq;
    st.acq = (state == PH_ACQ);
    st.dig = (state == PH_DIG);
    st.rd  = (state == PH_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
      doneP <= 1'b0;
    end else begin
      doneP <= (state == PH_READ) && lastCnt;
      case (state)
        PH_IDLE: begin
          cnt <= '0;
          if (startReq) state <= PH_ACQ;
        end
        default: begin
          if (lastCnt) begin
            cnt <= '0;
            case (state)
              PH_ACQ:  state <= PH_DIG;
              PH_DIG:  state <= PH_READ;
              default: state <= PH_IDLE;
            endcase
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R1
  acq_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_ACQ |=> (state == PH_ACQ || state == PH_DIG));

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_READ && !lastCnt) |=> state == PH_READ);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> state == PH_IDLE);
endmodule

// File: rtl/hit_acq_dp.sv
module hit_acq_dp
  import hit_acq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TS_W = 6,
  parameter int ADC_W = 6,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              trigSel,
  input  logic              extTrig,
  input  logic              calStrobe,
  input  logic [NCH-1:0]    chanEn,
  input  logic [NCH-1:0]    discHit,
  input  logic [NCH-1:0]    rangeDisc,
  input  logic [NCH*NREC-1:0] rampCmp,
  output logic              serOut
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [ADC_W-1:0] ADC_MAX = '1;

  logic [TS_W-1:0]  tsCnt;
  logic [ADC_W-1:0] ramp;
  logic [2:0]       hitCnt [NCH];
  logic [TS_W-1:0]  tsQ    [NCH][NREC];
  logic             rgQ    [NCH][NREC];
  logic [ADC_W-1:0] adcQ   [NCH][NREC];
  logic             ovfQ   [NCH][NREC];
  logic             latQ   [NCH][NREC];

  logic [CH_W-1:0]  rdCell;
  logic [3:0]       rdWord;
  logic [BIT_W-1:0] rdBit;
  logic [1:0]       rIdx;
  logic [WORD_W-1:0] curWord;
  logic             rampLast;

  assign rampLast = (ramp == ADC_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsCnt <= '0;
      ramp  <= '0;
    end else if (st.clr) begin
      tsCnt <= '0;
      ramp  <= '0;
    end else begin
      if (st.acq) tsCnt <= tsCnt + TS_W'(1);
      if (st.dig) ramp <= ramp + ADC_W'(1);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = chanEn[c] & (calStrobe | (trigSel ? extTrig : discHit[c]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitCnt[c] <= '0;
        for (int r = 0; r < NREC; r++) begin
          tsQ[c][r] <= '0; rgQ[c][r] <= 1'b0;
          adcQ[c][r] <= '0; ovfQ[c][r] <= 1'b0; latQ[c][r] <= 1'b0;
        end
      end else if (st.clr) begin
        hitCnt[c] <= '0;
        for (int r = 0; r < NREC; r++) begin
          tsQ[c][r] <= '0; rgQ[c][r] <= 1'b0;
          adcQ[c][r] <= '0; ovfQ[c][r] <= 1'b0; latQ[c][r] <= 1'b0;
        end
      end else if (st.acq) begin
        if (hit && hitCnt[c] < 3'(NREC)) begin
          tsQ[c][hitCnt[c][1:0]] <= tsCnt;
          rgQ[c][hitCnt[c][1:0]] <= rangeDisc[c];
          hitCnt[c] <= hitCnt[c] + 3'd1;
        end
      end else if (st.dig) begin
        for (int r = 0; r < NREC; r++) begin
          if (3'(r) < hitCnt[c] && !latQ[c][r] &&
              (rampCmp[c*NREC+r] || rampLast)) begin
            adcQ[c][r] <= ramp;
            ovfQ[c][r] <= !rampCmp[c*NREC+r];
            latQ[c][r] <= 1'b1;
          end
        end
      end
    end

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
      hitCnt[c] <= 3'(NREC));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (st.acq && hitCnt[c] == 3'(NREC)) |=> hitCnt[c] == 3'(NREC));

    for (genvar r = 0; r < NREC; r++) begin : g_rec
      // R8
      sat_code_chk: assert property (@(posedge clk) disable iff (!rstN)
        ovfQ[c][r] |-> adcQ[c][r] == ADC_MAX);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCell <= '0; rdWord <= '0; rdBit <= '0;
    end else if (st.clr) begin
      rdCell <= '0; rdWord <= '0; rdBit <= '0;
    end else if (st.rd) begin
      if (rdBit == BIT_W'(WORD_W - 1)) begin
        rdBit <= '0;
        if (rdWord == 4'(WORDS - 1)) begin
          rdWord <= '0;
          rdCell <= (rdCell == CH_W'(NCH - 1)) ? '0 : rdCell + CH_W'(1);
        end else begin
          rdWord <= rdWord + 4'd1;
        end
      end else begin
        rdBit <= rdBit + BIT_W'(1);
      end
    end
  end

  always_comb begin
    rIdx = (rdWord > 4'(NREC)) ? 2'(rdWord - 4'(NREC + 1)) : 2'(rdWord - 4'd1);
    curWord = '0;
    if (rdWord == 4'd0) begin
      curWord[2:0] = hitCnt[rdCell];
      curWord[3 +: CH_W] = rdCell;
    end else if (rdWord <= 4'(NREC)) begin
      curWord[TS_W-1:0] = tsQ[rdCell][rIdx];
      curWord[TS_W]     = rgQ[rdCell][rIdx];
      curWord[TS_W+1]   = ({1'b0, rIdx} < hitCnt[rdCell]);
    end else begin
      curWord[ADC_W-1:0] = adcQ[rdCell][rIdx];
      curWord[ADC_W]     = ovfQ[rdCell][rIdx];
    end
    serOut = st.rd ? curWord[BIT_W'(WORD_W - 1) - rdBit] : 1'b0;
  end

  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.rd |-> !serOut);
endmodule

// File: rtl/hit_acq_seq.sv
module hit_acq_seq
  import hit_acq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TS_W = 6,
  parameter int ADC_W = 6,
  parameter int ACQ_LEN = 40,
  parameter int WORD_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               trigSel,
  input  logic               extTrig,
  input  logic               calStrobe,
  input  logic [NCH-1:0]     chanEn,
  input  logic [NCH-1:0]     discHit,
  input  logic [NCH-1:0]     rangeDisc,
  input  logic [NCH*4-1:0]   rampCmp,
  output logic [1:0]         phase,
  output logic               serOut,
  output logic               frameValid,
  output logic               doneP
);
  localparam int DIG_LEN = 1 << ADC_W;
  localparam int READ_LEN = NCH * WORDS * WORD_W;

  phase_e  state;
  strobe_t st;

  hit_acq_ctrl #(.ACQ_LEN(ACQ_LEN), .DIG_LEN(DIG_LEN), .READ_LEN(READ_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .state(state), .st(st), .doneP(doneP)
  );

  hit_acq_dp #(.NCH(NCH), .TS_W(TS_W), .ADC_W(ADC_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .trigSel(trigSel), .extTrig(extTrig),
    .calStrobe(calStrobe), .chanEn(chanEn), .discHit(discHit),
    .rangeDisc(rangeDisc), .rampCmp(rampCmp), .serOut(serOut)
  );

  assign phase = state;
  assign frameValid = st.rd;
endmodule

// File: tb/sim_hit_acq_seq.sv
module sim_hit_acq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int TS_W = 6;
  localparam int ADC_W = 6;
  localparam int ACQ_LEN = 40;
  localparam int WORD_W = 10;
  localparam int DIG_LEN = 1 << ADC_W;
  localparam int AMAX = DIG_LEN - 1;

  logic clk = 0, rstN = 0, startReq = 0, trigSel = 0, extTrig = 0, calStrobe = 0;
  logic [NCH-1:0] chanEn = '0, discHit = '0, rangeDisc = '0;
  logic [NCH*4-1:0] rampCmp = '0;
  logic [1:0] phase;
  logic serOut, frameValid, doneP;

  int total = 0, bad = 0;
  int eCnt [NCH];
  int eTs [NCH][4];
  int eRg [NCH][4];
  int tgt [NCH][4];

  hit_acq_seq #(.NCH(NCH), .TS_W(TS_W), .ADC_W(ADC_W), .ACQ_LEN(ACQ_LEN), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .trigSel(trigSel), .extTrig(extTrig),
    .calStrobe(calStrobe), .chanEn(chanEn), .discHit(discHit), .rangeDisc(rangeDisc),
    .rampCmp(rampCmp), .phase(phase), .serOut(serOut), .frameValid(frameValid), .doneP(doneP)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expWord(input int c, input int w);
    int r;
    if (w == 0) return eCnt[c] + (c << 3);
    if (w <= 4) begin
      r = w - 1;
      if (r >= eCnt[c]) return 0;
      return (1 << (TS_W + 1)) + (eRg[c][r] << TS_W) + eTs[c][r];
    end
    r = w - 5;
    if (r >= eCnt[c]) return 0;
    if (tgt[c][r] > AMAX) return (1 << ADC_W) + AMAX;
    return tgt[c][r];
  endfunction

  task automatic runCycle(input int t, input bit mode, input bit useCal, input logic [NCH-1:0] en);
    int word;
    int bitN;
    chanEn = en; trigSel = mode;
    for (int c = 0; c < NCH; c++) begin
      eCnt[c] = 0;
      for (int r = 0; r < 4; r++) begin
        eTs[c][r] = 0; eRg[c][r] = 0;
        tgt[c][r] = (c * 17 + r * 23 + t * 11) % 80;
      end
    end
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
    chk(phase == 2'd1, "R1 acquire entry", phase, 1);
    for (int i = 0; i < ACQ_LEN; i++) begin
      extTrig = (i % 9 == t % 9);
      calStrobe = useCal && (i == 20);
      for (int c = 0; c < NCH; c++) begin
        bit h;
        discHit[c] = ((i * (c + 2) + t) % 5 == 0);
        rangeDisc[c] = ((i + c + t) % 3 == 0);
        // R5 R6 model: enable gates, cal in both modes
        h = en[c] && (calStrobe || (mode ? extTrig : discHit[c]));
        if (h && eCnt[c] < 4) begin
          eTs[c][eCnt[c]] = i;  // R3
          eRg[c][eCnt[c]] = rangeDisc[c];  // R4
          eCnt[c]++;
        end
      end
      if (i == 5) begin
        startReq = 1;  // R11 start during acquire
      end else begin
        startReq = 0;
      end
      @(negedge clk);
    end
    startReq = 0; extTrig = 0; calStrobe = 0; discHit = '0; rangeDisc = '0;
    chk(phase == 2'd2, "R1 digitize entry", phase, 2);
    for (int j = 0; j < DIG_LEN; j++) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < 4; r++) rampCmp[c*4+r] = (j >= tgt[c][r]);  // R7 R8
      @(negedge clk);
    end
    rampCmp = '0;
    chk(phase == 2'd3, "R1 readout entry", phase, 3);
    chk(frameValid == 1'b1, "R9 frameValid high", frameValid, 1);
    bitN = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < 9; w++) begin
        word = 0;
        for (int b = 0; b < WORD_W; b++) begin
          word = (word << 1) | int'(serOut);
          startReq = (bitN == 100);
          @(negedge clk);
          if (bitN == 100) chk(phase == 2'd3, "R11 start ignored in readout", phase, 3);
          bitN++;
        end
        chk(word == expWord(c, w), $sformatf("R9 R2 R3 R4 R7 R8 ch%0d word%0d", c, w),
            word, expWord(c, w));
      end
    end
    startReq = 0;
    chk(doneP == 1'b1, "R10 done pulse", doneP, 1);
    chk(frameValid == 1'b0, "R9 frameValid low after frame", frameValid, 0);
    chk(phase == 2'd0, "R1 back to idle", phase, 0);
    @(negedge clk);
    chk(doneP == 1'b0, "R10 done one cycle", doneP, 0);
    chk(phase == 2'd0, "R11 no restart", phase, 0);
    chk(serOut == 1'b0, "R9 line quiet", serOut, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(phase == 2'd0, "R12 reset phase", phase, 0);
    chk(frameValid == 1'b0, "R12 reset frameValid", frameValid, 0);
    chk(serOut == 1'b0, "R12 reset serOut", serOut, 0);
    chk(doneP == 1'b0, "R12 reset doneP", doneP, 0);
    runCycle(0, 1'b0, 1'b0, 4'b1111);
    runCycle(1, 1'b1, 1'b0, 4'b1011);
    runCycle(2, 1'b0, 1'b1, 4'b0110);
    runCycle(3, 1'b1, 1'b1, 4'b1111);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule